// File: doc/BRIEF.md
# Router Input Word Classifier FSM

This block is the control state machine of one input port of a circuit-switched router. Each cycle it may receive one 9-bit word, made of a control bit and eight data bits. It sorts the word into one of six kinds: routing request, forced-routing request, turn, idle filler, drop, or plain data. From that kind and its own state it decides whether to ask the output allocator for a port, pass the word to the crossbar, swallow it, start a turnaround, or close the path.

An allocation request is combinational. The allocator answers with a grant in the same cycle, and the FSM commits to either an open connection or a blocked path at the next clock edge. Words that are passed onward leave through a one-cycle register toward the crossbar. The block has no checksum logic and no handling of wire delay.

Top module: `rtr_inport_ctrl`

## Requirements
- R1: After reset, `conn_open`, `blocked`, `fwd_valid`, `turn_start`, `alloc_release` and `alloc_req` are all 0.
- R2: While idle, a valid word with the control bit 0 that is neither the filler code 0xAA nor a forced word raises `alloc_req` in the same cycle. `alloc_port` then equals data bits [2:0] and `alloc_forced` is 0. A word whose two top data bits are 11 counts as a routing word in this state.
- R3: While idle, a valid word with the control bit 0 and data bits [7:3] = 01010 raises `alloc_req` with `alloc_forced` = 1 and `alloc_port` = data bits [2:0]. When it is granted, the word is not forwarded, and the next valid word is the first one sent onward.
- R4: A granted normal routing word is forwarded one cycle later. From the next cycle on, `conn_open` is 1 and `conn_port` shows the granted port.
- R5: A request that is not granted, forced or normal, sets `blocked` from the next cycle. While blocked, no word is forwarded and no request is raised. A drop word returns the port to idle without an `alloc_release` pulse.
- R6: While connected, every valid word with the control bit 0 is forwarded unchanged one cycle later. This includes the filler code 0xAA. The state does not change, except for a turn (R7).
- R7: While connected, a word with the control bit 0 and data bits [7:6] = 11 is forwarded, and `turn_start` pulses in the next cycle. Afterwards the port stays open but forwards nothing until a drop word arrives.
- R8: A word with the control bit 1 (a drop), while connected or turning, is not forwarded. It produces a one-cycle `alloc_release` pulse in the next cycle and clears `conn_open` in that same cycle. `conn_port` still shows the released port during the pulse.
- R9: While idle, the filler code 0xAA with the control bit 0 raises no request and leaves the port idle.
- R10: A cycle with `in_valid` = 0 raises no request and changes no state.
- R11: A drop word while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is present this cycle |
| in_ctrl | input | 1 | Control bit of the word (1 = drop) |
| in_data | input | 8 | Data bits of the word |
| alloc_grant | input | 1 | Allocator grants the current request (same cycle) |
| alloc_req | output | 1 | Request for an output port |
| alloc_port | output | 3 | Requested output port |
| alloc_forced | output | 1 | Request comes from a forced-routing word |
| fwd_valid | output | 1 | Forwarded word is valid |
| fwd_data | output | 8 | Forwarded data bits |
| turn_start | output | 1 | One-cycle pulse: turnaround begun |
| alloc_release | output | 1 | One-cycle pulse: held output port freed |
| conn_port | output | 3 | Output port held by the connection |
| conn_open | output | 1 | Connection open (connected or turning) |
| blocked | output | 1 | Path blocked, waiting for a drop |

## Verification
If the port is left in the wrong state, the next word shows it at the outputs within one cycle. A stale idle state raises `alloc_req` on a data word in the same cycle it arrives. A stale connected or blocked state forwards or swallows a word in the wrong place, which shows on `fwd_valid` one cycle later. A missed drop shows up as a missing `alloc_release` pulse. A behavioural model in the bench predicts every output on every clock, so a divergence is reported in the cycle where it first appears. Directed sequences cover forced swallowing, blocking, turning and the filler code, and a long pseudo-random run covers the state paths the directed tests do not reach.

// File: rtl/rtr_inport_pkg.sv
package rtr_inport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONN = 2'd1,
        ST_BLK  = 2'd2,
        ST_TURN = 2'd3
    } inport_state_e;

    typedef enum logic [2:0] {
        WC_PLAIN = 3'd0,
        WC_TURN  = 3'd1,
        WC_FILL  = 3'd2,
        WC_FORCE = 3'd3,
        WC_DROP  = 3'd4
    } word_class_e;

endpackage

// File: rtl/rtr_word_classify.sv
module rtr_word_classify
    import rtr_inport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PORT_W = 3,
    parameter logic [DATA_W-PORT_W-1:0] FORCE_TAG = 5'b01010,
    parameter logic [DATA_W-1:0] FILL_CODE = 8'hAA
) (
    input  logic              ctrl,
    input  logic [DATA_W-1:0] data,
    output word_class_e       cls,
    output logic [PORT_W-1:0] port
);
    localparam int TAG_LSB = PORT_W;

    logic is_force;
    logic is_fill;
    logic is_turn;

    assign is_force = (data[DATA_W-1:TAG_LSB] == FORCE_TAG);
    assign is_fill  = (data == FILL_CODE);
    assign is_turn  = &data[DATA_W-1:DATA_W-2];
    assign port     = data[PORT_W-1:0];

    // drop wins over everything; the remaining codes do not overlap
    always_comb begin
        if (ctrl)          cls = WC_DROP;
        else if (is_fill)  cls = WC_FILL;
        else if (is_force) cls = WC_FORCE;
        else if (is_turn)  cls = WC_TURN;
        else               cls = WC_PLAIN;
    end

endmodule

// File: rtl/rtr_pipe_reg.sv
module rtr_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         vld,
    output logic [W-1:0] q
);
    logic         vld_q;
    logic [W-1:0] q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            q_q   <= '0;
        end else begin
            vld_q <= load;
            if (load) q_q <= d;
        end
    end

    assign vld = vld_q;
    assign q   = q_q;

endmodule

// File: rtl/rtr_inport_ctrl.sv
module rtr_inport_ctrl
    import rtr_inport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PORT_W = 3,
    parameter logic [DATA_W-PORT_W-1:0] FORCE_TAG = 5'b01010,
    parameter logic [DATA_W-1:0] FILL_CODE = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [DATA_W-1:0] in_data,
    input  logic              alloc_grant,
    output logic              alloc_req,
    output logic [PORT_W-1:0] alloc_port,
    output logic              alloc_forced,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              turn_start,
    output logic              alloc_release,
    output logic [PORT_W-1:0] conn_port,
    output logic              conn_open,
    output logic              blocked
);
    typedef struct packed {
        inport_state_e     st;
        logic [PORT_W-1:0] port;
        logic              rel;
        logic              turn;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, port: '0, rel: 1'b0, turn: 1'b0};

    word_class_e       cls;
    logic [PORT_W-1:0] cls_port;
    ctl_t              ctl_d;
    ctl_t              ctl_q;
    logic              req_d;
    logic              fwd_d;

    rtr_word_classify #(
        .DATA_W    (DATA_W),
        .PORT_W    (PORT_W),
        .FORCE_TAG (FORCE_TAG),
        .FILL_CODE (FILL_CODE)
    ) u_cls (
        .ctrl (in_ctrl),
        .data (in_data),
        .cls  (cls),
        .port (cls_port)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rel  = 1'b0;
        ctl_d.turn = 1'b0;
        req_d      = 1'b0;
        fwd_d      = 1'b0;
        if (in_valid) begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (cls == WC_PLAIN || cls == WC_TURN || cls == WC_FORCE) begin
                        req_d = 1'b1;
                        if (alloc_grant) begin
                            ctl_d.st   = ST_CONN;
                            ctl_d.port = cls_port;
                            fwd_d      = (cls != WC_FORCE);
                        end else begin
                            ctl_d.st = ST_BLK;
                        end
                    end
                end
                ST_CONN: begin
                    if (cls == WC_DROP) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.rel = 1'b1;
                    end else begin
                        fwd_d = 1'b1;
                        if (cls == WC_TURN) begin
                            ctl_d.st   = ST_TURN;
                            ctl_d.turn = 1'b1;
                        end
                    end
                end
                ST_BLK: begin
                    if (cls == WC_DROP) ctl_d.st = ST_IDLE;
                end
                ST_TURN: begin
                    if (cls == WC_DROP) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.rel = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    rtr_pipe_reg #(.W(DATA_W)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fwd_d),
        .d     (in_data),
        .vld   (fwd_valid),
        .q     (fwd_data)
    );

    assign alloc_req     = req_d;
    assign alloc_port    = req_d ? cls_port : '0;
    assign alloc_forced  = req_d && (cls == WC_FORCE);
    assign turn_start    = ctl_q.turn;
    assign alloc_release = ctl_q.rel;
    assign conn_port     = ctl_q.port;
    assign conn_open     = (ctl_q.st == ST_CONN) || (ctl_q.st == ST_TURN);
    assign blocked       = (ctl_q.st == ST_BLK);

endmodule

// File: rtl/rtr_inport_chk.sv
module rtr_inport_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic alloc_grant,
    input logic alloc_req,
    input logic alloc_forced,
    input logic fwd_valid,
    input logic turn_start,
    input logic alloc_release,
    input logic conn_open,
    input logic blocked
);
    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (!conn_open && !blocked)); // R2

    AST_FORCED_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_forced && alloc_grant) |=> !fwd_valid); // R3

    AST_GRANT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_grant) |=> conn_open); // R4

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !fwd_valid); // R5

    AST_FWD_NEEDS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ($past(conn_open) || $past(alloc_req && alloc_grant))); // R6

    AST_TURN_IN_CONN: assert property (@(posedge clk) disable iff (!rst_n)
        turn_start |-> conn_open); // R7

    AST_RELEASE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_release |-> (!conn_open && $past(conn_open))); // R8

    AST_NO_REQ_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !alloc_req); // R10

    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(conn_open && blocked)); // R5

endmodule

bind rtr_inport_ctrl rtr_inport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .alloc_grant   (alloc_grant),
    .alloc_req     (alloc_req),
    .alloc_forced  (alloc_forced),
    .fwd_valid     (fwd_valid),
    .turn_start    (turn_start),
    .alloc_release (alloc_release),
    .conn_open     (conn_open),
    .blocked       (blocked)
);

// File: tb/rtr_inport_ctrl_tb.sv
module rtr_inport_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ctrl = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       alloc_grant = 1'b0;
    logic       alloc_req;
    logic [2:0] alloc_port;
    logic       alloc_forced;
    logic       fwd_valid;
    logic [7:0] fwd_data;
    logic       turn_start;
    logic       alloc_release;
    logic [2:0] conn_port;
    logic       conn_open;
    logic       blocked;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model: 0 idle, 1 connected, 2 blocked, 3 turning
    int st = 0;
    int m_port = 0;
    int m_fv = 0;
    int m_fd = 0;
    int m_rel = 0;
    int m_turn = 0;

    always #4 clk = ~clk;

    rtr_inport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_data(in_data), .alloc_grant(alloc_grant), .alloc_req(alloc_req),
        .alloc_port(alloc_port), .alloc_forced(alloc_forced),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .turn_start(turn_start),
        .alloc_release(alloc_release), .conn_port(conn_port),
        .conn_open(conn_open), .blocked(blocked)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit c, input int d, input bit g, input string tag);
        int  req;
        int  frc;
        @(negedge clk);
        in_valid = v; in_ctrl = c; in_data = d[7:0]; alloc_grant = g;
        #1;
        frc = (!c && (d[7:3] == 5'b01010)) ? 1 : 0;
        req = (v && st == 0 && !c && d[7:0] != 8'hAA) ? 1 : 0;
        chk(tag, "alloc_req", int'(alloc_req), req);
        if (req != 0) begin
            chk(tag, "alloc_port", int'(alloc_port), d & 7);
            chk(tag, "alloc_forced", int'(alloc_forced), frc);
        end
        chk(tag, "fwd_valid", int'(fwd_valid), m_fv);
        if (m_fv != 0) chk(tag, "fwd_data", int'(fwd_data), m_fd);
        chk(tag, "turn_start", int'(turn_start), m_turn);
        chk(tag, "alloc_release", int'(alloc_release), m_rel);
        chk(tag, "conn_open", int'(conn_open), (st == 1 || st == 3) ? 1 : 0);
        chk(tag, "blocked", int'(blocked), (st == 2) ? 1 : 0);
        if (st != 0) chk(tag, "conn_port", int'(conn_port), m_port);
        // model update for the coming edge
        m_fv = 0; m_rel = 0; m_turn = 0;
        if (v) begin
            if (st == 0) begin
                if (req != 0) begin
                    if (g) begin
                        st = 1; m_port = d & 7; m_fv = frc ? 0 : 1; m_fd = d & 255;
                    end else st = 2;
                end
            end else if (st == 1) begin
                if (c) begin st = 0; m_rel = 1; end
                else begin
                    m_fv = 1; m_fd = d & 255;
                    if (d[7:6] == 2'b11) begin st = 3; m_turn = 1; end
                end
            end else if (st == 2) begin
                if (c) st = 0;
            end else begin
                if (c) begin st = 0; m_rel = 1; end
            end
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 8'h00, 0, "R1");
        // R10 invalid cycles with garbage
        step(0, 0, 8'h35, 1, "R10");
        step(0, 1, 8'hFF, 1, "R10");
        // R11 drop while idle
        step(1, 1, 8'h00, 1, "R11");
        step(0, 0, 8'h00, 0, "R11");
        // R9 filler while idle
        step(1, 0, 8'hAA, 1, "R9");
        step(0, 0, 8'h00, 0, "R9");
        // R2 / R4 normal routing, granted
        step(1, 0, 8'h35, 1, "R2");
        step(1, 0, 8'h12, 0, "R4");
        step(1, 0, 8'hAA, 0, "R6");
        step(0, 0, 8'h00, 0, "R6");
        step(1, 0, 8'h57, 0, "R6");
        // R7 turn, then quiet in turning
        step(1, 0, 8'hC3, 0, "R7");
        step(1, 0, 8'h44, 0, "R7");
        step(1, 0, 8'hFF, 0, "R7");
        // R8 drop from turning
        step(1, 1, 8'h00, 0, "R8");
        step(0, 0, 8'h00, 0, "R8");
        // R3 forced word swallowed
        step(1, 0, 8'h53, 1, "R3");
        step(1, 0, 8'h99, 0, "R3");
        step(1, 0, 8'h01, 0, "R3");
        step(1, 1, 8'h00, 0, "R8");
        step(0, 0, 8'h00, 0, "R8");
        // R2 turn pattern while idle is a routing word
        step(1, 0, 8'hC6, 1, "R2");
        step(1, 1, 8'h00, 0, "R8");
        // R5 blocked normal request
        step(1, 0, 8'h02, 0, "R5");
        step(1, 0, 8'h11, 1, "R5");
        step(1, 0, 8'h56, 1, "R5");
        step(1, 1, 8'h00, 0, "R5");
        step(0, 0, 8'h00, 0, "R5");
        // R5 blocked forced request
        step(1, 0, 8'h57, 0, "R5");
        step(1, 0, 8'hAA, 1, "R5");
        step(1, 1, 8'h00, 0, "R5");
        step(0, 0, 8'h00, 0, "R5");
        // pseudo-random run
        for (int i = 0; i < 3000; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >>> 17);
            seed = seed ^ (seed << 5);
            step(seed[0] | seed[1], seed[2] & seed[3] & seed[4], (seed[11] ? 8'hAA : int'(seed[19:12])),
                 seed[5] | seed[6], "R6");
        end
        step(0, 0, 8'h00, 0, "R6");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule